// File: doc/BRIEF.md
# Lockable Programmable Clock Divider

This block divides its reference clock by an integer that software places in a single 32-bit control register. A new factor is held in the register and does not reach the output until software also sets the load-request bit. The divider then changes ratio at the next end of an output period, waits for two whole output periods at the new ratio, and reports lock. The load-request bit clears when lock returns.

The same register carries an output enable and a domain-reset request. The enable is also applied only at a period boundary. The reset request drives a reset output for a fixed number of reference cycles and then clears itself. A factor of 0 or 1 lets the reference clock through undivided. Odd factors give a high phase that is one cycle longer than the low phase.

Lock is tracked by a three-state machine. `LK_LOCKED` is the reset state and the steady state. A write with the load bit set moves any state to `LK_WAIT_EDGE`. From `LK_WAIT_EDGE`, the next period boundary applies the new factor and moves to `LK_SETTLE`. `LK_SETTLE` returns to `LK_LOCKED` at the second period boundary of the new ratio.

Top module: `refdiv_unit`

## Requirements
- R1: After reset, a read of address 0 returns 0x8000_0000: enable 0, factor 0, no requests pending, lock 1. The divided output and the domain reset output are both 0.
- R2: Register layout at address 0 is: enable at bit 0, reset request at bit 1, load request at bit 2, factor at bits [4 +: FACTOR_W], lock at bit 31 (bit 27 when LOCK_AT_27 is set). Every other bit reads 0. A write to any other address changes nothing, and a read of any other address returns 0.
- R3: A write that changes the factor without the load bit leaves lock at 1 and leaves the output ratio unchanged. The register reads back the new factor.
- R4: A write with the load bit set makes lock read 0 in the following cycle and makes the load bit read 1 until lock returns. Lock returns no later than 4 × max(old, new) reference cycles after the write, counting a factor of 0 as 1. The load bit reads 0 once lock is back.
- R5: For a factor N ≥ 2, the output period is N reference cycles. The output is high for ceil(N/2) cycles and low for floor(N/2) cycles.
- R6: With a factor of 0 or 1 and enable set, the output follows the reference clock.
- R7: The active ratio changes only at the end of an output period. Across a ratio change, every high or low phase has the length of either the old ratio or the new ratio.
- R8: While enable is 0, the output stays low, and a factor can be loaded and locked. Enable is applied at a period boundary. After enable is set, the output runs at the loaded ratio.
- R9: A write with bit 1 set raises the domain reset output at the write edge. The output stays high for exactly RST_CYCLES reference cycles. Bit 1 reads 1 while the pulse lasts and clears itself when it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register address; only address 0 is decoded |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| div_clk_o | output | 1 | Gated divided clock |
| domain_rst_o | output | 1 | Downstream domain reset pulse, active high |

## Verification
The assertions take for granted that the write strobe and write data are stable around each rising edge. They also take for granted that at most one write lands per cycle. The bench meets both conditions by driving every register access on the falling edge and holding it for one full cycle. The boundary-only checks on ratio and enable assume that the factor field never changes the active ratio outside a load. The stimulus issues a new load only after lock has returned, so each lock-time bound is measured from a known old ratio.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
    localparam int EN_BIT     = 0;
    localparam int RSTREQ_BIT = 1;
    localparam int LOAD_BIT   = 2;
    localparam int FACTOR_LSB = 4;
    localparam int LOCK_MAIN  = 31;
    localparam int LOCK_ALT   = 27;

    typedef enum logic [1:0] {
        LK_LOCKED    = 2'd0,
        LK_WAIT_EDGE = 2'd1,
        LK_SETTLE    = 2'd2
    } lock_state_e;
endpackage

// File: rtl/refdiv_regs.sv
module refdiv_regs #(
    parameter int FACTOR_W   = 8,
    parameter int RST_CYCLES = 250
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_hit,
    input  logic                wr_en_bit,
    input  logic                wr_rst_bit,
    input  logic                wr_load_bit,
    input  logic [FACTOR_W-1:0] wr_factor,
    input  logic                settle_done,
    output logic                en_o,
    output logic [FACTOR_W-1:0] factor_o,
    output logic                load_o,
    output logic                rst_req_o
);
    localparam int RCNT_W = $clog2(RST_CYCLES + 1);

    logic [RCNT_W-1:0] rcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_o      <= 1'b0;
            factor_o  <= '0;
            load_o    <= 1'b0;
            rst_req_o <= 1'b0;
            rcnt_q    <= '0;
        end else begin
            if (wr_hit) begin
                en_o     <= wr_en_bit;
                factor_o <= wr_factor;
            end
            if (wr_hit && wr_load_bit)
                load_o <= 1'b1;
            else if (settle_done)
                load_o <= 1'b0;
            if (wr_hit && wr_rst_bit) begin
                rst_req_o <= 1'b1;
                rcnt_q    <= RCNT_W'(RST_CYCLES - 1);
            end else if (rst_req_o) begin
                if (rcnt_q == '0)
                    rst_req_o <= 1'b0;
                else
                    rcnt_q <= rcnt_q - 1'b1;
            end
        end
    end

    AST_RST_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req_o) |-> $past(wr_hit && wr_rst_bit)); // R9
endmodule

// File: rtl/refdiv_lockfsm.sv
module refdiv_lockfsm
    import refdiv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_wr,
    input  logic bnd,
    output logic apply_o,
    output logic done_o,
    output logic lock_o
);
    lock_state_e state_q, state_d;
    logic        second_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_LOCKED:    if (load_wr) state_d = LK_WAIT_EDGE;
            LK_WAIT_EDGE: if (!load_wr && bnd) state_d = LK_SETTLE;
            LK_SETTLE: begin
                if (load_wr)              state_d = LK_WAIT_EDGE;
                else if (bnd && second_q) state_d = LK_LOCKED;
            end
            default:                  state_d = LK_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= LK_LOCKED;
            second_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q != LK_SETTLE || load_wr)
                second_q <= 1'b0;
            else if (bnd)
                second_q <= 1'b1;
        end
    end

    always_comb begin
        apply_o = (state_q == LK_WAIT_EDGE);
        lock_o  = (state_q == LK_LOCKED);
        done_o  = (state_q == LK_SETTLE) && bnd && second_q && !load_wr;
    end

    AST_LOCK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr |=> !lock_o); // R4
endmodule

// File: rtl/refdiv_core.sv
module refdiv_core #(
    parameter int FACTOR_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                apply,
    input  logic [FACTOR_W-1:0] new_factor,
    input  logic                en,
    output logic                bnd_o,
    output logic                div_clk_o
);
    logic [FACTOR_W-1:0] act_q, cnt_q, eff, nxt_act, nxt_eff, nxt_cnt;
    logic [FACTOR_W:0]   hi_len;
    logic                out_q, en_q, byp;

    always_comb begin
        eff     = (act_q == '0) ? FACTOR_W'(1) : act_q;
        bnd_o   = (cnt_q == eff - FACTOR_W'(1));
        nxt_act = (bnd_o && apply) ? new_factor : act_q;
        nxt_eff = (nxt_act == '0) ? FACTOR_W'(1) : nxt_act;
        nxt_cnt = bnd_o ? '0 : cnt_q + FACTOR_W'(1);
        hi_len  = ({1'b0, nxt_eff} + 1'b1) >> 1;
        byp     = (act_q <= FACTOR_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= '0;
            cnt_q <= '0;
            out_q <= 1'b0;
            en_q  <= 1'b0;
        end else begin
            act_q <= nxt_act;
            cnt_q <= nxt_cnt;
            out_q <= ({1'b0, nxt_cnt} < hi_len);
            if (bnd_o)
                en_q <= en;
        end
    end

    assign div_clk_o = en_q & (byp ? clk : out_q);

    AST_RATIO_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !bnd_o |=> $stable(act_q)); // R7
    AST_GATE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !bnd_o |=> $stable(en_q)); // R8
endmodule

// File: rtl/refdiv_unit.sv
module refdiv_unit
    import refdiv_pkg::*;
#(
    parameter int FACTOR_W   = 8,
    parameter int ADDR_W     = 4,
    parameter int RST_CYCLES = 250,
    parameter bit LOCK_AT_27 = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              reg_we,
    output logic [31:0]       reg_rdata,
    output logic              div_clk_o,
    output logic              domain_rst_o
);
    localparam int LOCK_POS = LOCK_AT_27 ? LOCK_ALT : LOCK_MAIN;

    logic                addr_hit, wr_hit, load_wr;
    logic                en, load, rst_req, settle_done, apply, lock, bnd;
    logic [FACTOR_W-1:0] factor;
    logic                wdata_unused;

    assign addr_hit     = (reg_addr == '0);
    assign wr_hit       = reg_we && addr_hit;
    assign load_wr      = wr_hit && reg_wdata[LOAD_BIT];
    assign wdata_unused = ^{reg_wdata[3], reg_wdata[31:FACTOR_LSB+FACTOR_W]};

    refdiv_regs #(.FACTOR_W(FACTOR_W), .RST_CYCLES(RST_CYCLES)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_hit     (wr_hit),
        .wr_en_bit  (reg_wdata[EN_BIT]),
        .wr_rst_bit (reg_wdata[RSTREQ_BIT]),
        .wr_load_bit(reg_wdata[LOAD_BIT]),
        .wr_factor  (reg_wdata[FACTOR_LSB +: FACTOR_W]),
        .settle_done(settle_done),
        .en_o       (en),
        .factor_o   (factor),
        .load_o     (load),
        .rst_req_o  (rst_req)
    );

    refdiv_lockfsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_wr(load_wr),
        .bnd    (bnd),
        .apply_o(apply),
        .done_o (settle_done),
        .lock_o (lock)
    );

    refdiv_core #(.FACTOR_W(FACTOR_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .apply     (apply),
        .new_factor(factor),
        .en        (en),
        .bnd_o     (bnd),
        .div_clk_o (div_clk_o)
    );

    assign domain_rst_o = rst_req;

    always_comb begin
        reg_rdata = '0;
        if (addr_hit) begin
            reg_rdata[EN_BIT]                   = en;
            reg_rdata[RSTREQ_BIT]               = rst_req;
            reg_rdata[LOAD_BIT]                 = load;
            reg_rdata[FACTOR_LSB +: FACTOR_W]   = factor;
            reg_rdata[LOCK_POS]                 = lock;
        end
    end

    AST_LOAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !lock |-> load); // R4
    AST_LOCK_CLEARS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> !load); // R4
endmodule

// File: tb/test_refdiv_unit.sv
`timescale 1ns/1ps
module test_refdiv_unit;
    localparam int RST_LEN = 250;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_rdata;
    logic        div_clk_o, domain_rst_o;

    int errors = 0;
    int checks = 0;
    int cur_n  = 1;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    refdiv_unit i_refdiv_unit (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .div_clk_o(div_clk_o),
        .domain_rst_o(domain_rst_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int effn(input int n);
        return (n == 0) ? 1 : n;
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = '0;
        #1;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_addr = '0;
    endtask

    task automatic load_and_lock(input int n, input bit en, input string req);
        int k = 0;
        int bound;
        bound = 4 * ((effn(n) > cur_n) ? effn(n) : cur_n);
        wr(4'd0, (32'(n) << 4) | 32'h4 | 32'(en));
        check(reg_rdata[31] == 1'b0, {req, " R4 lock drops"}, reg_rdata[31], 0);
        check(reg_rdata[2] == 1'b1, {req, " R4 load pending"}, reg_rdata[2], 1);
        while (!reg_rdata[31] && k < 400) begin
            @(negedge clk); #1; k++;
        end
        check(k <= bound, {req, " R4 lock time"}, k, bound);
        check(reg_rdata[2] == 1'b0, {req, " R4 load self-clear"}, reg_rdata[2], 0);
        cur_n = effn(n);
    endtask

    task automatic measure(output int hi, output int lo);
        logic prev, cur;
        int t = 0;
        hi = 0; lo = 0;
        @(negedge clk); #1 prev = div_clk_o;
        @(negedge clk); #1 cur = div_clk_o;
        while (!(prev == 1'b0 && cur == 1'b1) && t < 200) begin
            prev = cur; @(negedge clk); #1 cur = div_clk_o; t++;
        end
        while (cur && hi < 100) begin
            hi++; @(negedge clk); #1 cur = div_clk_o;
        end
        while (!cur && lo < 100) begin
            lo++; @(negedge clk); #1 cur = div_clk_o;
        end
    endtask

    task automatic check_ratio(input int n, input string req);
        int hi, lo;
        measure(hi, lo);
        check(hi == (n + 1) / 2, {req, " high phase"}, hi, (n + 1) / 2);
        check(lo == n / 2, {req, " low phase"}, lo, n / 2);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(4'd0, d);
        check(d == 32'h8000_0000, "R1 reset readback", d, 32'h8000_0000);
        check(div_clk_o == 1'b0 && domain_rst_o == 1'b0, "R1 outputs idle",
              {div_clk_o, domain_rst_o}, 0);
    endtask

    task automatic t_layout;
        logic [31:0] d;
        wr(4'd0, 32'h0000_05A1);
        rd(4'd0, d);
        check(d == 32'h8000_05A1, "R2 field layout", d, 32'h8000_05A1);
        wr(4'd1, 32'hFFFF_FFFF);
        rd(4'd0, d);
        check(d == 32'h8000_05A1, "R2 other address ignored", d, 32'h8000_05A1);
        check(domain_rst_o == 1'b0, "R2 no reset from other address", domain_rst_o, 0);
        rd(4'd1, d);
        check(d == 32'h0, "R2 other address reads zero", d, 0);
    endtask

    task automatic t_ratios;
        load_and_lock(4, 1'b1, "R5 n=4");
        check_ratio(4, "R5 n=4");
        load_and_lock(7, 1'b1, "R5 n=7");
        check_ratio(7, "R5 n=7");
        load_and_lock(2, 1'b1, "R5 n=2");
        check_ratio(2, "R5 n=2");
        load_and_lock(3, 1'b1, "R5 n=3");
        check_ratio(3, "R5 n=3");
    endtask

    task automatic t_bypass(input int n);
        load_and_lock(n, 1'b1, "R6 bypass");
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            check(div_clk_o == 1'b1, "R6 follows clock high", div_clk_o, 1);
            @(negedge clk); #1;
            check(div_clk_o == 1'b0, "R6 follows clock low", div_clk_o, 0);
        end
    endtask

    task automatic t_hold;
        load_and_lock(4, 1'b1, "R3 base");
        wr(4'd0, 32'h0000_0081);
        check(reg_rdata == 32'h8000_0081, "R3 factor stored, lock kept",
              reg_rdata, 32'h8000_0081);
        check_ratio(4, "R3 ratio unchanged");
        load_and_lock(8, 1'b1, "R3 load");
        check_ratio(8, "R3 new ratio");
    endtask

    task automatic t_switch;
        logic s [0:79];
        int run, bad;
        load_and_lock(4, 1'b1, "R7 base");
        wr(4'd0, 32'h0000_0065);
        for (int i = 0; i < 80; i++) begin
            @(negedge clk); #1 s[i] = div_clk_o;
        end
        cur_n = 6;
        bad = 0; run = 0;
        for (int i = 1; i < 80; i++) begin
            if (s[i] == s[i-1]) run++;
            else begin
                if (run != 0 && run != 2 && run != 3) bad++;
                run = 1;
            end
        end
        check(bad == 0, "R7 no runt phases", bad, 0);
        check_ratio(6, "R7 settled on new ratio");
    endtask

    task automatic t_gate;
        int seen = 0;
        load_and_lock(5, 1'b0, "R8 gated load");
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); #1 if (div_clk_o) seen++;
        end
        check(seen == 0, "R8 gated output low", seen, 0);
        wr(4'd0, 32'h0000_0051);
        check_ratio(5, "R8 enabled ratio");
    endtask

    task automatic t_domain_reset;
        int k = 0;
        wr(4'd0, 32'h0000_0053);
        check(reg_rdata[1] == 1'b1, "R9 request visible", reg_rdata[1], 1);
        while (domain_rst_o && k < 1000) begin
            k++; @(negedge clk); #1;
        end
        check(k == RST_LEN, "R9 pulse length", k, RST_LEN);
        check(reg_rdata[1] == 1'b0, "R9 request self-clears", reg_rdata[1], 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_layout();
        t_ratios();
        t_bypass(1);
        t_bypass(0);
        t_hold();
        t_switch();
        t_gate();
        t_domain_reset();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule